// File: doc/BRIEF.md
# Interlaced 625-Line Composite Sync Generator

This block generates the sync and black-level waveform for an interlaced 625-line composite video output. It drives a two-bit code into an external resistor ladder. Both bits low give the sync tip, and bit 0 alone high gives black. Each normal line opens with a short sync pulse followed by a back porch. The block keeps a running frame line number. Downstream pixel logic uses that number together with a one-cycle strobe that marks the end of the back porch.

Whenever the line number stands at the end of a field at a line boundary, the block replaces the normal line with a vertical interval. That interval is a train of narrow equalising pulses, then broad vertical-sync pulses, then a second train of narrow pulses. The number of narrow pulses depends on which field is ending. After the interval the line number is reloaded to a field-specific value and counting resumes.

All durations are counted in clock cycles from a microsecond scale parameter (20 cycles per microsecond by default). Dropping the enable, or applying the synchronous reset, parks the output at sync level and restarts generation cleanly.

Top module: `psg_sync_gen`

## Requirements
- R1: The level output uses code 2'b00 for sync and 2'b01 for black; bit 1 is always 0.
- R2: A normal line is 64 us long. It starts with 4 us of sync, followed by 8 us of back porch and 52 us of active time, both at black.
- R3: On a normal line the line number rises by exactly 1, and it does so in the first sync cycle of that line.
- R4: porch_done is high for exactly one cycle on each normal line: the first cycle after the 8 us back porch ends, while the output is black. It is never high during a vertical interval.
- R5: When the line number at a line boundary is 310 or 622, a vertical interval is emitted in place of a line. The line number holds its value for the whole interval.
- R6: The interval opens with narrow pulses, each 2 us of sync then 30 us of black. There are 5 of them after line 310 and 6 after line 622.
- R7: Next come 5 broad pulses, each 30 us of sync then 2 us of black. No sync run is ever longer than 30 us.
- R8: The interval closes with narrow pulses of the same shape as in R6: 4 after line 310 and 5 after line 622.
- R9: In the cycle after the last closing pulse ends, a normal line begins. The counter is reloaded to 317 (after 310) or 5 (after 622) and advanced on that sync, so the line shows 318 or 6.
- R10: While enable is low, from the next cycle on the outputs are level 2'b00, line 0 and porch_done 0. Once enable is sampled high, the first line's sync starts in the following cycle with line number 1.
- R11: Synchronous reset has the same effect as enable low and takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; timing scale set by CLK_PER_US |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generation enable |
| level | output | 2 | Ladder code: 00 sync, 01 black |
| line_no | output | LINE_W | Current frame line number |
| porch_done | output | 1 | One-cycle strobe at end of back porch |

## Verification
Two events can land on the same clock edge. One is the end of the last closing pulse of a vertical interval. The other is the start of the next line, where the line counter takes both its field reload and its per-line advance at once. The bench drives a full frame through both field ends, so each case (after 310 and after 622) happens. The per-cycle reference must show 318 or 6 together with the first sync cycle, and never the bare reload value. A second coincidence is an enable drop or a reset in the middle of a line. There the reference expects idle on the very next cycle, and a restart at line 1.

// File: rtl/psg_pkg.sv
package psg_pkg;

  typedef enum logic [2:0] {
    SG_IDLE,
    SG_HSYNC,
    SG_PORCH,
    SG_ACTIVE,
    SG_EQ_LO,
    SG_EQ_HI,
    SG_BR_LO,
    SG_BR_HI
  } seg_e;

  typedef enum logic [1:0] {
    PH_PRE,
    PH_BROAD,
    PH_POST
  } vphase_e;

  localparam logic [1:0] LVL_SYNC  = 2'b00;
  localparam logic [1:0] LVL_BLACK = 2'b01;

  // Scale a microsecond figure into clock cycles.
  function automatic int unsigned us_to_clk(int unsigned us, int unsigned cpu);
    return us * cpu;
  endfunction

  // Ladder code for each segment.
  function automatic logic [1:0] seg_level(seg_e s);
    case (s)
      SG_IDLE, SG_HSYNC, SG_EQ_LO, SG_BR_LO: return LVL_SYNC;
      default:                              return LVL_BLACK;
    endcase
  endfunction

  function automatic logic seg_is_vertical(seg_e s);
    return (s == SG_EQ_LO) || (s == SG_EQ_HI) || (s == SG_BR_LO) || (s == SG_BR_HI);
  endfunction

  // Smallest width that can hold the value v.
  function automatic int unsigned width_for(int unsigned v);
    int unsigned w;
    w = 1;
    while ((1 << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/psg_seg_timer.sv
// Single down-counter that times every segment of the waveform.
module psg_seg_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             seg_end
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign seg_end = (cnt_q == '0);

endmodule

// File: rtl/psg_line_ctr.sv
// Frame line number: cleared, advanced, or reloaded-and-advanced.
module psg_line_ctr #(
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned RELOAD1 = 317,
  parameter int unsigned RELOAD2 = 5
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              inc,
  input  logic              reload,
  input  logic              sel2,
  output logic [LINE_W-1:0] line_o
);

  localparam logic [LINE_W-1:0] NEXT_AFTER1 = LINE_W'(RELOAD1 + 1);
  localparam logic [LINE_W-1:0] NEXT_AFTER2 = LINE_W'(RELOAD2 + 1);

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (clr)
      line_q <= '0;
    else if (reload)
      line_q <= sel2 ? NEXT_AFTER2 : NEXT_AFTER1;
    else if (inc)
      line_q <= line_q + 1'b1;
  end

  assign line_o = line_q;

endmodule

// File: rtl/psg_seq.sv
// Segment sequencer: normal lines and the three-phase vertical interval.
module psg_seq
  import psg_pkg::*;
#(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned HSYNC_CYC  = 80,
  parameter int unsigned PORCH_CYC  = 160,
  parameter int unsigned ACTIVE_CYC = 1040,
  parameter int unsigned HALF_CYC   = 640,
  parameter int unsigned EQ_CYC     = 40,
  parameter int unsigned GAP_CYC    = 40,
  parameter int unsigned FIELD1_END = 310,
  parameter int unsigned FIELD2_END = 622,
  parameter int unsigned PRE1       = 5,
  parameter int unsigned PRE2       = 6,
  parameter int unsigned BROAD_N    = 5,
  parameter int unsigned POST1      = 4,
  parameter int unsigned POST2      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              seg_end_i,
  input  logic [LINE_W-1:0] line_i,
  output seg_e              seg_o,
  output logic              timer_clr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              line_clr_o,
  output logic              line_inc_o,
  output logic              line_reload_o,
  output logic              reload_sel2_o,
  output logic              porch_done_o,
  output logic              vert_active_o
);

  localparam int unsigned PW = width_for(PRE1 + PRE2 + BROAD_N + POST1 + POST2);
  localparam logic [LINE_W-1:0] END1 = LINE_W'(FIELD1_END);
  localparam logic [LINE_W-1:0] END2 = LINE_W'(FIELD2_END);
  localparam logic [PW-1:0] N_PRE1  = PW'(PRE1);
  localparam logic [PW-1:0] N_PRE2  = PW'(PRE2);
  localparam logic [PW-1:0] N_BROAD = PW'(BROAD_N);
  localparam logic [PW-1:0] N_POST1 = PW'(POST1);
  localparam logic [PW-1:0] N_POST2 = PW'(POST2);
  localparam logic [PW-1:0] ONE     = PW'(1);

  // Length of a segment minus one, as loaded into the timer.
  function automatic logic [CNT_W-1:0] len_m1(seg_e s);
    int unsigned n;
    case (s)
      SG_HSYNC:  n = HSYNC_CYC;
      SG_PORCH:  n = PORCH_CYC;
      SG_ACTIVE: n = ACTIVE_CYC;
      SG_EQ_LO:  n = EQ_CYC;
      SG_EQ_HI:  n = HALF_CYC - EQ_CYC;
      SG_BR_LO:  n = HALF_CYC - GAP_CYC;
      SG_BR_HI:  n = GAP_CYC;
      default:   n = 1;
    endcase
    return CNT_W'(n - 1);
  endfunction

  seg_e    seg_q, seg_n;
  vphase_e phase_q, phase_n;
  logic [PW-1:0] left_q, left_n;
  logic    fsel_q, fsel_n;
  logic    pd_q;

  logic hold, seg_done, tick, vdone, adv, at_end, at_end2;

  assign hold     = rst | ~en;
  assign seg_done = seg_end_i && (seg_q != SG_IDLE);
  assign at_end2  = (line_i == END2);
  assign at_end   = (line_i == END1) || at_end2;

  always_comb begin
    seg_n   = seg_q;
    phase_n = phase_q;
    left_n  = left_q;
    fsel_n  = fsel_q;
    tick    = 1'b0;
    vdone   = 1'b0;
    adv     = 1'b0;
    case (seg_q)
      SG_IDLE:   tick = 1'b1;
      SG_HSYNC:  if (seg_done) seg_n = SG_PORCH;
      SG_PORCH:  if (seg_done) seg_n = SG_ACTIVE;
      SG_ACTIVE: if (seg_done) tick = 1'b1;
      SG_EQ_LO:  if (seg_done) seg_n = SG_EQ_HI;
      SG_EQ_HI: begin
        if (seg_done) begin
          if (left_q > ONE) begin
            seg_n  = SG_EQ_LO;
            left_n = left_q - ONE;
          end else if (phase_q == PH_PRE) begin
            seg_n   = SG_BR_LO;
            phase_n = PH_BROAD;
            left_n  = N_BROAD;
          end else begin
            vdone = 1'b1;
          end
        end
      end
      SG_BR_LO:  if (seg_done) seg_n = SG_BR_HI;
      SG_BR_HI: begin
        if (seg_done) begin
          if (left_q > ONE) begin
            seg_n  = SG_BR_LO;
            left_n = left_q - ONE;
          end else begin
            seg_n   = SG_EQ_LO;
            phase_n = PH_POST;
            left_n  = fsel_q ? N_POST2 : N_POST1;
          end
        end
      end
      default: seg_n = SG_IDLE;
    endcase

    if (vdone) begin
      seg_n   = SG_HSYNC;
      phase_n = PH_PRE;
    end else if (tick) begin
      if (at_end) begin
        seg_n   = SG_EQ_LO;
        phase_n = PH_PRE;
        fsel_n  = at_end2;
        left_n  = at_end2 ? N_PRE2 : N_PRE1;
      end else begin
        seg_n = SG_HSYNC;
        adv   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      seg_q   <= SG_IDLE;
      phase_q <= PH_PRE;
      left_q  <= '0;
      fsel_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      seg_q   <= seg_n;
      phase_q <= phase_n;
      left_q  <= left_n;
      fsel_q  <= fsel_n;
      pd_q    <= (seg_q == SG_PORCH) && seg_done;
    end
  end

  assign seg_o         = seg_q;
  assign timer_clr_o   = hold;
  assign load_o        = ~hold & (seg_done | (seg_q == SG_IDLE));
  assign load_val_o    = len_m1(seg_n);
  assign line_clr_o    = hold;
  assign line_inc_o    = adv;
  assign line_reload_o = vdone;
  assign reload_sel2_o = fsel_q;
  assign porch_done_o  = pd_q;
  assign vert_active_o = seg_is_vertical(seg_q);

endmodule

// File: rtl/psg_sync_gen.sv
// Top: composite sync generator for interlaced 625-line video.
module psg_sync_gen
  import psg_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 20,
  parameter int unsigned LINE_US    = 64,
  parameter int unsigned HSYNC_US   = 4,
  parameter int unsigned PORCH_US   = 8,
  parameter int unsigned EQ_US      = 2,
  parameter int unsigned GAP_US     = 2,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned FIELD1_END = 310,
  parameter int unsigned FIELD2_END = 622,
  parameter int unsigned RELOAD1    = 317,
  parameter int unsigned RELOAD2    = 5,
  parameter int unsigned PRE1       = 5,
  parameter int unsigned PRE2       = 6,
  parameter int unsigned BROAD_N    = 5,
  parameter int unsigned POST1      = 4,
  parameter int unsigned POST2      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [1:0]        level,
  output logic [LINE_W-1:0] line_no,
  output logic              porch_done
);

  localparam int unsigned HSYNC_CYC  = us_to_clk(HSYNC_US, CLK_PER_US);
  localparam int unsigned PORCH_CYC  = us_to_clk(PORCH_US, CLK_PER_US);
  localparam int unsigned ACTIVE_CYC = us_to_clk(LINE_US - HSYNC_US - PORCH_US, CLK_PER_US);
  localparam int unsigned HALF_CYC   = us_to_clk(LINE_US / 2, CLK_PER_US);
  localparam int unsigned EQ_CYC     = us_to_clk(EQ_US, CLK_PER_US);
  localparam int unsigned GAP_CYC    = us_to_clk(GAP_US, CLK_PER_US);
  localparam int unsigned CNT_W      = width_for(us_to_clk(LINE_US, CLK_PER_US));

  // Internal events brought out as named wires.
  seg_e              seg;
  logic              seg_end;
  logic              timer_clr, timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              line_clr, line_inc, line_reload, reload_sel2;
  logic              vert_active;
  logic [LINE_W-1:0] line_w;

  psg_seg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .clr      (timer_clr),
    .load     (timer_load),
    .load_val (timer_val),
    .seg_end  (seg_end)
  );

  psg_line_ctr #(
    .LINE_W  (LINE_W),
    .RELOAD1 (RELOAD1),
    .RELOAD2 (RELOAD2)
  ) u_line (
    .clk    (clk),
    .clr    (line_clr),
    .inc    (line_inc),
    .reload (line_reload),
    .sel2   (reload_sel2),
    .line_o (line_w)
  );

  psg_seq #(
    .CNT_W      (CNT_W),
    .LINE_W     (LINE_W),
    .HSYNC_CYC  (HSYNC_CYC),
    .PORCH_CYC  (PORCH_CYC),
    .ACTIVE_CYC (ACTIVE_CYC),
    .HALF_CYC   (HALF_CYC),
    .EQ_CYC     (EQ_CYC),
    .GAP_CYC    (GAP_CYC),
    .FIELD1_END (FIELD1_END),
    .FIELD2_END (FIELD2_END),
    .PRE1       (PRE1),
    .PRE2       (PRE2),
    .BROAD_N    (BROAD_N),
    .POST1      (POST1),
    .POST2      (POST2)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .seg_end_i     (seg_end),
    .line_i        (line_w),
    .seg_o         (seg),
    .timer_clr_o   (timer_clr),
    .load_o        (timer_load),
    .load_val_o    (timer_val),
    .line_clr_o    (line_clr),
    .line_inc_o    (line_inc),
    .line_reload_o (line_reload),
    .reload_sel2_o (reload_sel2),
    .porch_done_o  (porch_done),
    .vert_active_o (vert_active)
  );

  assign level   = seg_level(seg);
  assign line_no = line_w;

endmodule

// File: rtl/psg_sync_gen_chk.sv
module psg_sync_gen_chk #(
  parameter int unsigned LINE_W       = 10,
  parameter int unsigned BROAD_LO_CYC = 600,
  parameter int unsigned F1           = 310,
  parameter int unsigned F2           = 622,
  parameter int unsigned NEXT1        = 318,
  parameter int unsigned NEXT2        = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        level,
  input logic [LINE_W-1:0] line_no,
  input logic              porch_done,
  input logic              vert_active
);

  localparam int unsigned RUN_W = $clog2(BROAD_LO_CYC + 2) + 1;
  localparam logic [LINE_W-1:0] E1 = LINE_W'(F1);
  localparam logic [LINE_W-1:0] E2 = LINE_W'(F2);
  localparam logic [LINE_W-1:0] N1 = LINE_W'(NEXT1);
  localparam logic [LINE_W-1:0] N2 = LINE_W'(NEXT2);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || !en)
      low_run <= '0;
    else if (level == 2'b00)
      low_run <= low_run + 1'b1;
    else
      low_run <= '0;
  end

  p_bit1_zero_r1: assert property (@(posedge clk) disable iff (rst)
    level[1] == 1'b0);

  p_sync_run_r7: assert property (@(posedge clk) disable iff (rst)
    low_run <= RUN_W'(BROAD_LO_CYC));

  p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst) && (line_no != $past(line_no))) |->
      ((line_no == $past(line_no) + 1'b1) ||
       (($past(line_no) == E1) && (line_no == N1)) ||
       (($past(line_no) == E2) && (line_no == N2))));

  p_pd_single_r4: assert property (@(posedge clk) disable iff (rst)
    porch_done |=> !porch_done);

  p_pd_black_r4: assert property (@(posedge clk) disable iff (rst)
    porch_done |-> (level == 2'b01) && !vert_active);

  p_vert_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vert_active) |-> (($past(line_no) == E1) || ($past(line_no) == E2)));

  p_vert_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (vert_active && $past(vert_active)) |-> $stable(line_no));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level == 2'b00) && (line_no == '0) && !porch_done);

  p_reset_r11: assert property (@(posedge clk)
    rst |=> (level == 2'b00) && (line_no == '0) && !porch_done);

endmodule

bind psg_sync_gen psg_sync_gen_chk #(
  .LINE_W       (LINE_W),
  .BROAD_LO_CYC ((LINE_US / 2 - GAP_US) * CLK_PER_US),
  .F1           (FIELD1_END),
  .F2           (FIELD2_END),
  .NEXT1        (RELOAD1 + 1),
  .NEXT2        (RELOAD2 + 1)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .level       (level),
  .line_no     (line_no),
  .porch_done  (porch_done),
  .vert_active (vert_active)
);

// File: tb/sim_psg_sync_gen.sv
module sim_psg_sync_gen;

  localparam int CPU     = 2;
  localparam int LINE    = 64 * CPU;
  localparam int HALF    = LINE / 2;
  localparam int HS      = 4 * CPU;
  localparam int BP      = 8 * CPU;
  localparam int NARROW  = 2 * CPU;
  localparam int TAILGAP = 2 * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] level;
  logic [9:0] line_no;
  logic       porch_done;

  psg_sync_gen #(.CLK_PER_US(CPU)) u0 (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .level      (level),
    .line_no    (line_no),
    .porch_done (porch_done)
  );

  always #5 clk = ~clk;

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;
  bit done       = 1'b0;
  logic rst_q = 1'b1;
  logic en_q  = 1'b0;

  always @(posedge clk) begin
    rst_q <= rst;
    en_q  <= en;
    cyc   <= cyc + 1;
  end

  // Reference: queue of expected samples, one per clock.
  // Packed as region[19:16], porch strobe[12], level[11:10], line[9:0].
  int exp_q[$];
  int ref_line = 0;
  bit after_vert = 1'b0;

  function automatic void push(int n, int region, int lvl, int pd);
    for (int i = 0; i < n; i++)
      exp_q.push_back((region << 16) | (pd << 12) | (lvl << 10) | ref_line);
  endfunction

  function automatic void gen_slot();
    int  npre;
    int  npost;
    bit  second;
    if (ref_line == 310 || ref_line == 622) begin
      // R5: vertical interval, line held
      second = (ref_line == 622);
      npre  = second ? 6 : 5;           // R6
      npost = second ? 5 : 4;           // R8
      for (int k = 0; k < npre; k++) begin
        push(NARROW, 5, 0, 0);
        push(HALF - NARROW, 5, 1, 0);
      end
      for (int k = 0; k < 5; k++) begin // R7
        push(HALF - TAILGAP, 6, 0, 0);
        push(TAILGAP, 6, 1, 0);
      end
      for (int k = 0; k < npost; k++) begin
        push(NARROW, 7, 0, 0);
        push(HALF - NARROW, 7, 1, 0);
      end
      ref_line   = second ? 5 : 317;    // R9 reload
      after_vert = 1'b1;
    end else begin
      ref_line = ref_line + 1;          // R3
      push(HS, after_vert ? 8 : 1, 0, 0);   // R2 sync
      push(BP, 2, 1, 0);                    // R2 porch
      push(1, 3, 1, 1);                     // R4 strobe
      push(LINE - HS - BP - 1, 4, 1, 0);    // R2 active
      after_vert = 1'b0;
    end
  endfunction

  function automatic string tag_of(int region, bit lvl1_bad, bit line_bad, bit pd_bad);
    if (lvl1_bad)     return "R1";
    if (region == 10) return "R11";
    if (region == 9)  return "R10";
    if (line_bad) begin
      if (region >= 5 && region <= 7) return "R5";
      if (region == 8) return "R9";
      return "R3";
    end
    if (pd_bad) return "R4";
    case (region)
      3:       return "R4";
      5:       return "R6";
      6:       return "R7";
      7:       return "R8";
      8:       return "R9";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin : cmp
    int e;
    int region;
    int e_line;
    int e_lvl;
    int e_pd;
    if (!done) begin
      if (rst_q || !en_q) begin
        exp_q.delete();
        ref_line   = 0;
        after_vert = 1'b0;
        region = rst_q ? 10 : 9;
        e_line = 0;
        e_lvl  = 0;
        e_pd   = 0;
      end else begin
        if (exp_q.size() == 0) gen_slot();
        e      = exp_q.pop_front();
        region = (e >> 16) & 15;
        e_pd   = (e >> 12) & 1;
        e_lvl  = (e >> 10) & 3;
        e_line = e & 1023;
      end
      compared++;
      if (level !== 2'(e_lvl) || line_no !== 10'(e_line) || porch_done !== 1'(e_pd)) begin
        mismatched++;
        $display("FAIL %s at cycle %0d: level=%b exp=%b line=%0d exp=%0d porch_done=%b exp=%0d",
                 tag_of(region, level[1] !== 1'b0, line_no !== 10'(e_line),
                        porch_done !== 1'(e_pd)),
                 cyc, level, 2'(e_lvl), line_no, e_line, porch_done, e_pd);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL R10 watchdog: cycles=%0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R11: held in reset; then R10: enable low keeps idle
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    // R10: start at line 1, run some lines
    #1 en = 1'b1;
    repeat (3000) @(posedge clk);
    // R10: enable drop mid-line, then clean restart
    #1 en = 1'b0;
    repeat (7) @(posedge clk);
    #1 en = 1'b1;
    // full frame: both field ends, R5..R9
    repeat (84000) @(posedge clk);
    // R11: reset in the middle of running
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (1500) @(posedge clk);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule